// File: doc/BRIEF.md
# Triple-Buffer Frame Rate Arbiter

This block shares three frame buffers between a video writer and a video reader whose frame rates may differ. It holds only the buffer assignments; the pixel path and the memory are outside it. Both sides run on the same clock. Each side pulses a one-cycle "frame finished" input, and the block answers on registered outputs with the buffer index each side must use next.

When the writer finishes, the frame it just filled becomes the newest complete frame. The writer then moves to the one buffer that is neither being read nor holding that newest frame. When the reader finishes, it moves to the newest complete frame if one has arrived since it last switched. Otherwise it stays where it is and shows the same frame again.

A fast writer therefore overwrites whole unread frames, so frames are dropped only as complete units. A fast reader repeats frames. Neither side is ever left without a buffer. When both pulses arrive in the same cycle, the write is taken first, so the reader picks up the frame that has just been completed.

Top module: `frame_triple_arbiter`

## Requirements
- R1: While reset is high, and in the first cycle after it is released, the write index is 0 and the read index is 1. No completed frame is pending after reset, so a read-done that comes before any write-done leaves the reader on buffer 1.
- R2: Buffer indices are 2-bit binary values in the range 0..2. The write index and the read index always differ.
- R3: A write-done pulse without a read-done pulse moves the write index, one cycle later, to the index equal to neither the old write index nor the read index. The read index is unchanged.
- R4: A read-done pulse after at least one write-done since the reader last switched moves the read index, one cycle later, to the buffer the writer was using at the most recent write-done.
- R5: A read-done pulse with no write-done since the reader last switched, and none in the same cycle, leaves the read index unchanged, so the frame is repeated.
- R6: When write-done and read-done arrive in the same cycle, the read index moves to the old write index and the write index moves to the third buffer.
- R7: When several write-dones arrive between two read-dones, the next read-done selects only the latest completed buffer. The earlier frames are dropped whole.
- R8: In a cycle with no pulse, both indices hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by writer and reader |
| rst | input | 1 | Synchronous active-high reset |
| wr_frame_done | input | 1 | One-cycle pulse: writer finished its frame |
| rd_frame_done | input | 1 | One-cycle pulse: reader finished its frame |
| wr_buf | output | 2 | Buffer index assigned to the writer |
| rd_buf | output | 2 | Buffer index assigned to the reader |

## Verification
The bench builds the block with its default of three buffers and 2-bit indices, which is the only buffer count for which the "third buffer" rule is defined. The 2-bit width makes the unused code 3 reachable, so the range check means something. The three-buffer count lets a short pulse sequence reach every rotation of writer, reader and newest frame. Within that sequence the bench covers dropped frames, repeated frames, simultaneous pulses and a reset taken in the middle of operation.

// File: rtl/frame_triple_pkg.sv
package frame_triple_pkg;
  localparam int NUM_BUFS = 3;
  localparam int IDX_W    = $clog2(NUM_BUFS);
  // sum of all buffer indices 0..NUM_BUFS-1
  localparam int IDX_SUM  = NUM_BUFS * (NUM_BUFS - 1) / 2;

  typedef logic [IDX_W-1:0] buf_idx_t;

  typedef struct packed {
    buf_idx_t wr;
    buf_idx_t rd;
    buf_idx_t newest;
    logic     fresh;   // newest frame not yet taken by the reader
  } arb_state_t;

  localparam buf_idx_t RST_WR = buf_idx_t'(0);
  localparam buf_idx_t RST_RD = buf_idx_t'(1);
endpackage

// File: rtl/frame_triple_third.sv
module frame_triple_third
  import frame_triple_pkg::*;
(
  input  buf_idx_t a,
  input  buf_idx_t b,
  output buf_idx_t other
);
  int sum_ab;
  always_comb begin
    sum_ab = int'(a) + int'(b);
    other  = buf_idx_t'(IDX_SUM - sum_ab);
  end
endmodule

// File: rtl/frame_triple_next.sv
module frame_triple_next
  import frame_triple_pkg::*;
(
  input  arb_state_t cur,
  input  logic       wr_done,
  input  logic       rd_done,
  output arb_state_t nxt
);
  buf_idx_t   spare;
  arb_state_t mid;

  frame_triple_third u_third (
    .a     (cur.wr),
    .b     (cur.rd),
    .other (spare)
  );

  always_comb begin
    // write side first
    mid = cur;
    if (wr_done) begin
      mid.newest = cur.wr;
      mid.wr     = spare;
      mid.fresh  = 1'b1;
    end
    // then read side, seeing the write of this cycle
    nxt = mid;
    if (rd_done && mid.fresh) begin
      nxt.rd    = mid.newest;
      nxt.fresh = 1'b0;
    end
  end
endmodule

// File: rtl/frame_triple_arbiter.sv
module frame_triple_arbiter
  import frame_triple_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_frame_done,
  input  logic             rd_frame_done,
  output logic [IDX_W-1:0] wr_buf,
  output logic [IDX_W-1:0] rd_buf
);
  arb_state_t state_q;
  arb_state_t state_d;

  frame_triple_next u_next (
    .cur     (state_q),
    .wr_done (wr_frame_done),
    .rd_done (rd_frame_done),
    .nxt     (state_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q.wr     <= RST_WR;
      state_q.rd     <= RST_RD;
      state_q.newest <= RST_RD;
      state_q.fresh  <= 1'b0;
    end else begin
      state_q <= state_d;
    end
  end

  assign wr_buf = state_q.wr;
  assign rd_buf = state_q.rd;
endmodule

// File: rtl/frame_triple_arbiter_chk.sv
module frame_triple_arbiter_chk
  import frame_triple_pkg::*;
(
  input logic     clk,
  input logic     rst,
  input logic     wr_done,
  input logic     rd_done,
  input buf_idx_t wr_buf,
  input buf_idx_t rd_buf
);
  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (wr_buf == RST_WR && rd_buf == RST_RD));

  assert_distinct_R2: assert property (@(posedge clk) disable iff (rst)
    wr_buf != rd_buf);

  assert_in_range_R2: assert property (@(posedge clk) disable iff (rst)
    (int'(wr_buf) < NUM_BUFS) && (int'(rd_buf) < NUM_BUFS));

  assert_write_moves_R3: assert property (@(posedge clk) disable iff (rst)
    (wr_done && !rd_done) |=>
      (wr_buf != $past(wr_buf) && wr_buf != $past(rd_buf) && $stable(rd_buf)));

  assert_both_pulses_R6: assert property (@(posedge clk) disable iff (rst)
    (wr_done && rd_done) |=> (rd_buf == $past(wr_buf)));

  assert_idle_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (!wr_done && !rd_done) |=> ($stable(wr_buf) && $stable(rd_buf)));
endmodule

bind frame_triple_arbiter frame_triple_arbiter_chk u_chk (
  .clk     (clk),
  .rst     (rst),
  .wr_done (wr_frame_done),
  .rd_done (rd_frame_done),
  .wr_buf  (wr_buf),
  .rd_buf  (rd_buf)
);

// File: tb/sim_frame_triple_arbiter.sv
module sim_frame_triple_arbiter;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wd  = 1'b0;
  logic       rdd = 1'b0;
  logic [1:0] wr_buf;
  logic [1:0] rd_buf;
  int n_run  = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  frame_triple_arbiter u0 (
    .clk           (clk),
    .rst           (rst),
    .wr_frame_done (wd),
    .rd_frame_done (rdd),
    .wr_buf        (wr_buf),
    .rd_buf        (rd_buf)
  );

  // {write_done, read_done, expected wr, expected rd}, from reset wr0 rd1
  localparam int NV = 12;
  localparam logic [5:0] VEC [NV] = '{
    {1'b0, 1'b1, 2'd0, 2'd1},  // R5 read-done with nothing new
    {1'b1, 1'b0, 2'd2, 2'd1},  // R3 writer to third buffer
    {1'b0, 1'b0, 2'd2, 2'd1},  // R8 idle
    {1'b0, 1'b1, 2'd2, 2'd0},  // R4 reader takes buffer 0
    {1'b0, 1'b1, 2'd2, 2'd0},  // R5 repeat
    {1'b1, 1'b0, 2'd1, 2'd0},  // R3
    {1'b1, 1'b0, 2'd2, 2'd0},  // R7 frame in 2 dropped
    {1'b0, 1'b1, 2'd2, 2'd1},  // R7 latest only
    {1'b1, 1'b1, 2'd0, 2'd2},  // R6
    {1'b1, 1'b1, 2'd1, 2'd0},  // R6
    {1'b0, 1'b1, 2'd1, 2'd0},  // R5
    {1'b1, 1'b0, 2'd2, 2'd0}   // R3
  };

  task automatic check(input string req, input logic [1:0] ew, input logic [1:0] er);
    n_run++;
    if (wr_buf !== ew || rd_buf !== er) begin
      n_fail++;
      $display("FAIL %s: wr=%0d rd=%0d expected wr=%0d rd=%0d", req, wr_buf, rd_buf, ew, er);
    end
  endtask

  task automatic check_r2;
    n_run++;
    if (wr_buf === rd_buf || wr_buf > 2'd2 || rd_buf > 2'd2) begin
      n_fail++;
      $display("FAIL R2: wr=%0d rd=%0d expected distinct values in 0..2", wr_buf, rd_buf);
    end
  endtask

  task automatic step(input logic w, input logic r);
    @(negedge clk);
    wd  = w;
    rdd = r;
    @(negedge clk);
    wd  = 1'b0;
    rdd = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1", 2'd0, 2'd1);
    rst = 1'b0;
    @(negedge clk);
    check("R1", 2'd0, 2'd1);

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][5], VEC[i][4]);
      check($sformatf("vec%0d", i), VEC[i][3:2], VEC[i][1:0]);
      check_r2();
    end

    // R1: reset mid-operation restores start state and clears pending frame
    step(1'b1, 1'b0);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R1", 2'd0, 2'd1);
    step(1'b0, 1'b1);
    check("R1", 2'd0, 2'd1);

    // R7: three writes then one read picks only the latest (old wr at 3rd write)
    step(1'b1, 1'b0);  // newest0 wr2
    step(1'b1, 1'b0);  // newest2 wr0
    step(1'b1, 1'b0);  // newest0 wr2
    check("R7", 2'd2, 2'd1);
    step(1'b0, 1'b1);
    check("R7", 2'd2, 2'd0);
    check_r2();

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule